// File: doc/BRIEF.md
# Flash Reset Configuration Loader and Command Gate

This block sits between a flash array and the rest of a microcontroller core. After every reset it stalls the processor and walks through four configuration bytes stored at fixed flash locations: a control parameter byte, a protection byte, a nonvolatile option byte and a security byte. Each byte is read through a simple read port with one cycle of read latency and latched into a register that drives the rest of the chip. The stall is released only once the last byte has been captured.

The block also guards the start of flash program and erase operations. A start request is let through only when the flash clock divider has been configured, either by a processor write or by a preload from the debug side, and only when the divider brings the derived flash clock into the 150 kHz to 200 kHz window. A request that fails this test is dropped and raises a sticky access-error flag. A reset during an operation aborts it at once. The program and erase pulse engine and the array timing lie outside the block. The engine receives the accept pulse and reports completion back to the block.

Top module: `fcfg_boot_gate`

## Requirements
- R1: `cpu_hold` is 1 while `rst` is 1 and for exactly 5 clock cycles after the first cycle in which `rst` is 0; it is 0 afterwards until the next reset.
- R2: After reset release, `fl_rd_en` is 1 for exactly four consecutive cycles, with `fl_rd_addr` equal to CFG_BASE+0, +1, +2, +3 in that order. These are the control, protection, nonvolatile option and security bytes. `fl_rd_en` is 0 at all other times, including during reset.
- R3: The byte on `fl_rd_data` in the cycle after a read of CFG_BASE+k is latched into the k-th configuration output: 0 = `cfg_ctrl`, 1 = `cfg_prot`, 2 = `cfg_nvopt`, 3 = `cfg_sec`. All four are valid when `cpu_hold` falls and are 0 after reset.
- R4: A `cmd_start` with `cpu_hold` 0 and `cmd_busy` 0 while `div_set` is 0 produces no `cmd_go`, leaves `cmd_busy` 0, and sets `acc_err` from the next cycle on.
- R5: With divider value d, the flash clock is in range when 150*(d+1) <= BUS_KHZ <= 200*(d+1). A `cmd_start` while the value is out of range is rejected in the same way as in R4. With BUS_KHZ = 8000, d = 39..52 is in range and d = 38 or 53 is not.
- R6: A `cmd_start` with `cpu_hold` 0, `cmd_busy` 0, `div_set` 1 and an in-range divider gives `cmd_go` = 1 in the same cycle. `cmd_busy` is then 1 from the next cycle until the cycle after `cmd_done` is seen.
- R7: A `cmd_start` while `cmd_busy` or `cpu_hold` is 1 is ignored: no `cmd_go` and no change to `acc_err`.
- R8: `div_wr` or `dbg_div_ld` loads `div_value` and sets `div_set` in the next cycle. `div_wr` has priority when both are present. Both are ignored while `cmd_busy` is 1.
- R9: `div_set` and `acc_err` are cleared only by reset.
- R10: A reset while `cmd_busy` is 1 aborts the operation: `cmd_busy` is 0 in the cycle after `rst` is sampled, `div_set` is cleared and the configuration fetch runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_hold | output | 1 | Stalls the processor during the configuration fetch |
| fl_rd_en | output | 1 | Flash read request |
| fl_rd_addr | output | AW | Flash read address |
| fl_rd_data | input | 8 | Flash read data, valid one cycle after the request |
| cfg_ctrl | output | 8 | Latched control parameter byte |
| cfg_prot | output | 8 | Latched protection byte |
| cfg_nvopt | output | 8 | Latched nonvolatile option byte |
| cfg_sec | output | 8 | Latched security byte |
| div_wr | input | 1 | Processor write strobe for the clock divider |
| div_wdata | input | DW | Processor divider value |
| dbg_div_ld | input | 1 | Debug-side divider preload strobe |
| dbg_div_data | input | DW | Debug-side divider value |
| div_value | output | DW | Current clock divider |
| div_set | output | 1 | Divider has been written since reset |
| cmd_start | input | 1 | Program or erase start request |
| cmd_done | input | 1 | Completion from the pulse engine |
| cmd_go | output | 1 | Start request accepted (same cycle) |
| cmd_busy | output | 1 | Operation in progress |
| acc_err | output | 1 | Sticky access error for rejected requests |

## Verification
The fetch is tried with two different flash images across successive resets, which shows that every reset re-reads the array and that each byte lands in its own slot rather than a shifted one. Start requests are issued with no divider, with dividers on both sides of each range boundary, through both write paths, during the stall and during an operation. This separates rejection with an error from silent dropping. A reset in the middle of an operation and a collision between the processor and debug writes exercise abort and write priority. A behavioural model is compared with every output on every cycle.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;

    localparam int NCFG = 4;

    // Fetch walks the read states in order, then one capture-only state.
    typedef enum logic [2:0] {
        FS_RD_CTRL  = 3'd0,
        FS_RD_PROT  = 3'd1,
        FS_RD_NVOPT = 3'd2,
        FS_RD_SEC   = 3'd3,
        FS_TAIL     = 3'd4,
        FS_IDLE     = 3'd5
    } fetch_st_t;

    // Read issued last cycle, whose data is on the bus now.
    typedef struct packed {
        logic       vld;
        logic [1:0] slot;
    } pend_t;

    // Flash clock bus_khz/(div+1) must lie in [lo_khz, hi_khz].
    function automatic logic div_in_range(input int unsigned div,
                                          input int unsigned bus_khz,
                                          input int unsigned lo_khz,
                                          input int unsigned hi_khz);
        return (lo_khz * (div + 1) <= bus_khz) && (bus_khz <= hi_khz * (div + 1));
    endfunction

endpackage

// File: rtl/fcfg_fetch_seq.sv
module fcfg_fetch_seq
    import fcfg_pkg::*;
#(
    parameter int            AW   = 8,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic                  hold,
    output logic                  rd_en,
    output logic [AW-1:0]         rd_addr,
    input  logic [7:0]            rd_data,
    output logic [NCFG-1:0][7:0]  cfg
);

    fetch_st_t st;
    pend_t     pend;
    logic      reading;

    assign reading = (st < FS_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= FS_RD_CTRL;
            pend <= '0;
        end else begin
            if (st != FS_IDLE) st <= fetch_st_t'(st + 3'd1);
            pend.vld  <= reading;
            pend.slot <= st[1:0];
        end
    end

    for (genvar g = 0; g < NCFG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                              cfg[g] <= '0;
            else if (pend.vld && pend.slot == 2'(g)) cfg[g] <= rd_data;
        end
    end

    assign rd_en   = reading && !rst;
    assign rd_addr = BASE + AW'(st[1:0]);
    assign hold    = (st != FS_IDLE);

    // R2: consecutive reads step the address by one
    assert_addr_order_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> rd_addr == $past(rd_addr) + AW'(1));

    // R1: once the stall is released no more reads are issued
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !hold |-> !rd_en);

endmodule

// File: rtl/fcfg_div_reg.sv
module fcfg_div_reg
    import fcfg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int BUS_KHZ = 8000,
    parameter int LO_KHZ  = 150,
    parameter int HI_KHZ  = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_data,
    input  logic          dbg_ld,
    input  logic [DW-1:0] dbg_data,
    output logic [DW-1:0] div_q,
    output logic          div_set,
    output logic          div_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            div_set <= 1'b0;
        end else if (!busy_i && (cpu_wr || dbg_ld)) begin
            div_q   <= cpu_wr ? cpu_data : dbg_data;
            div_set <= 1'b1;
        end
    end

    assign div_ok = div_in_range(32'(div_q), BUS_KHZ, LO_KHZ, HI_KHZ);

    // R9: written flag never drops outside reset
    assert_div_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        div_set |=> div_set);

    // R8: divider frozen while an operation runs
    assert_div_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(div_q));

endmodule

// File: rtl/fcfg_cmd_gate.sv
module fcfg_cmd_gate (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic div_set_i,
    input  logic div_ok_i,
    input  logic cmd_start,
    input  logic cmd_done,
    output logic cmd_go,
    output logic busy,
    output logic acc_err
);

    logic eligible;
    logic clk_ready;

    assign eligible  = cmd_start && !hold_i && !busy;
    assign clk_ready = div_set_i && div_ok_i;
    assign cmd_go    = eligible && clk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            acc_err <= 1'b0;
        end else begin
            if (cmd_go)        busy <= 1'b1;
            else if (cmd_done) busy <= 1'b0;
            if (eligible && !clk_ready) acc_err <= 1'b1;
        end
    end

    // R10: reset aborts any operation
    assert_abort_R10: assert property (@(posedge clk)
        rst |=> !busy);

    // R4: start without a divider is rejected with an error
    assert_reject_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !hold_i && !busy && !div_set_i) |=> (acc_err && !busy));

    // R6: accepted start makes the gate busy
    assert_go_busy_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> busy);

    // R9: error flag sticky until reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        acc_err |=> acc_err);

endmodule

// File: rtl/fcfg_boot_gate.sv
module fcfg_boot_gate
    import fcfg_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] CFG_BASE = 'hF0,
    parameter int            BUS_KHZ  = 8000,
    parameter int            LO_KHZ   = 150,
    parameter int            HI_KHZ   = 200
) (
    input  logic          clk,
    input  logic          rst,
    output logic          cpu_hold,
    output logic          fl_rd_en,
    output logic [AW-1:0] fl_rd_addr,
    input  logic [7:0]    fl_rd_data,
    output logic [7:0]    cfg_ctrl,
    output logic [7:0]    cfg_prot,
    output logic [7:0]    cfg_nvopt,
    output logic [7:0]    cfg_sec,
    input  logic          div_wr,
    input  logic [DW-1:0] div_wdata,
    input  logic          dbg_div_ld,
    input  logic [DW-1:0] dbg_div_data,
    output logic [DW-1:0] div_value,
    output logic          div_set,
    input  logic          cmd_start,
    input  logic          cmd_done,
    output logic          cmd_go,
    output logic          cmd_busy,
    output logic          acc_err
);

    logic [NCFG-1:0][7:0] cfg_w;
    logic                 div_ok_w;

    fcfg_fetch_seq #(.AW(AW), .BASE(CFG_BASE)) fetch_i (
        .clk     (clk),
        .rst     (rst),
        .hold    (cpu_hold),
        .rd_en   (fl_rd_en),
        .rd_addr (fl_rd_addr),
        .rd_data (fl_rd_data),
        .cfg     (cfg_w)
    );

    assign cfg_ctrl  = cfg_w[0];
    assign cfg_prot  = cfg_w[1];
    assign cfg_nvopt = cfg_w[2];
    assign cfg_sec   = cfg_w[3];

    fcfg_div_reg #(.DW(DW), .BUS_KHZ(BUS_KHZ), .LO_KHZ(LO_KHZ), .HI_KHZ(HI_KHZ)) div_i (
        .clk      (clk),
        .rst      (rst),
        .busy_i   (cmd_busy),
        .cpu_wr   (div_wr),
        .cpu_data (div_wdata),
        .dbg_ld   (dbg_div_ld),
        .dbg_data (dbg_div_data),
        .div_q    (div_value),
        .div_set  (div_set),
        .div_ok   (div_ok_w)
    );

    fcfg_cmd_gate gate_i (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (cpu_hold),
        .div_set_i (div_set),
        .div_ok_i  (div_ok_w),
        .cmd_start (cmd_start),
        .cmd_done  (cmd_done),
        .cmd_go    (cmd_go),
        .busy      (cmd_busy),
        .acc_err   (acc_err)
    );

endmodule

// File: tb/fcfg_boot_gate_tb.sv
`timescale 1ns/1ps
module fcfg_boot_gate_tb_top;

    localparam int BASE = 'hF0;
    localparam int BUS  = 8000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_hold, fl_rd_en;
    logic [7:0] fl_rd_addr, fl_rd_data;
    logic [7:0] cfg_ctrl, cfg_prot, cfg_nvopt, cfg_sec;
    logic       div_wr = 0, dbg_div_ld = 0, cmd_start = 0, cmd_done = 0;
    logic [7:0] div_wdata = 0, dbg_div_data = 0;
    logic [7:0] div_value;
    logic       div_set, cmd_go, cmd_busy, acc_err;

    logic [7:0] mem [256];
    logic [7:0] rdq;
    assign fl_rd_data = rdq;

    always #2.5 clk = ~clk;

    fcfg_boot_gate dut_i (
        .clk(clk), .rst(rst), .cpu_hold(cpu_hold), .fl_rd_en(fl_rd_en),
        .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
        .cfg_ctrl(cfg_ctrl), .cfg_prot(cfg_prot), .cfg_nvopt(cfg_nvopt), .cfg_sec(cfg_sec),
        .div_wr(div_wr), .div_wdata(div_wdata), .dbg_div_ld(dbg_div_ld),
        .dbg_div_data(dbg_div_data), .div_value(div_value), .div_set(div_set),
        .cmd_start(cmd_start), .cmd_done(cmd_done), .cmd_go(cmd_go),
        .cmd_busy(cmd_busy), .acc_err(acc_err)
    );

    // flash array with one cycle of read latency
    always @(posedge clk) if (fl_rd_en) rdq <= mem[fl_rd_addr];

    // behavioural reference model
    int         m_cyc = 0;
    int         m_cfg [4] = '{0, 0, 0, 0};
    int         m_div = 0;
    bit         m_dset = 0, m_busy = 0, m_err = 0;
    int         vectors = 0, fails = 0, ticks = 0;
    bit         finished = 0;

    function automatic bit in_range(int d);
        return (150 * (d + 1) <= BUS) && (BUS <= 200 * (d + 1));
    endfunction

    always @(posedge clk) begin
        bit elig, ready;
        if (rst) begin
            m_cyc = 0; m_div = 0; m_dset = 0; m_busy = 0; m_err = 0;
            for (int i = 0; i < 4; i++) m_cfg[i] = 0;
        end else begin
            elig  = cmd_start && m_cyc >= 5 && !m_busy;
            ready = m_dset && in_range(m_div);
            if (m_cyc >= 1 && m_cyc <= 4) m_cfg[m_cyc-1] = mem[BASE + m_cyc - 1];
            if (elig && !ready) m_err = 1;
            if (!m_busy && (div_wr || dbg_div_ld)) begin
                m_div  = div_wr ? int'(div_wdata) : int'(dbg_div_data);
                m_dset = 1;
            end
            if (elig && ready)  m_busy = 1;
            else if (cmd_done)  m_busy = 0;
            if (m_cyc < 5) m_cyc++;
        end
    end

    task automatic cmp(string req, string nm, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit e_rd, e_go;
        if (!finished) begin
            vectors++;
            e_rd = !rst && m_cyc < 4;
            e_go = cmd_start && m_cyc >= 5 && !m_busy && m_dset && in_range(m_div);
            cmp("R1", "cpu_hold", int'(cpu_hold), int'(m_cyc < 5));
            cmp("R2", "fl_rd_en", int'(fl_rd_en), int'(e_rd));
            if (e_rd) cmp("R2", "fl_rd_addr", int'(fl_rd_addr), BASE + m_cyc);
            cmp("R3", "cfg_ctrl",  int'(cfg_ctrl),  m_cfg[0]);
            cmp("R3", "cfg_prot",  int'(cfg_prot),  m_cfg[1]);
            cmp("R3", "cfg_nvopt", int'(cfg_nvopt), m_cfg[2]);
            cmp("R3", "cfg_sec",   int'(cfg_sec),   m_cfg[3]);
            cmp("R4/R5/R9", "acc_err", int'(acc_err), int'(m_err));
            cmp("R6/R7", "cmd_go", int'(cmd_go), int'(e_go));
            cmp("R6/R10", "cmd_busy", int'(cmd_busy), int'(m_busy));
            cmp("R8", "div_value", int'(div_value), m_div);
            cmp("R8/R9", "div_set", int'(div_set), int'(m_dset));
        end
    end

    // watchdog
    always @(posedge clk) begin
        ticks++;
        if (ticks > 5000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", ticks);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_start();
        cmd_start = 1; tick(1); cmd_start = 0;
    endtask

    task automatic cpu_div(int d);
        div_wr = 1; div_wdata = 8'(d); tick(1); div_wr = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        // R1 R2 R3: first fetch after power-on reset
        tick(3); rst = 0; tick(8);
        // R4: start before any divider write
        pulse_start(); tick(2);
        // R9 R10 R3: new image, reset clears error and refetches
        for (int i = 0; i < 4; i++) mem[BASE + i] = 8'(8'hA0 + i * 17);
        rst = 1; tick(2); rst = 0; tick(8);
        // R5: divider 38 is below the range
        cpu_div(38); pulse_start(); tick(2);
        rst = 1; tick(2); rst = 0; tick(7);
        // R8 R6: debug preload 45, start accepted
        dbg_div_ld = 1; dbg_div_data = 45; tick(1); dbg_div_ld = 0;
        pulse_start(); tick(1);
        // R7 R8: start and write during operation ignored
        div_wr = 1; div_wdata = 50; cmd_start = 1; tick(1);
        div_wr = 0; cmd_start = 0; tick(2);
        cmd_done = 1; tick(1); cmd_done = 0; tick(1);
        // R8: both write paths in one cycle, processor wins
        div_wr = 1; div_wdata = 39; dbg_div_ld = 1; dbg_div_data = 60; tick(1);
        div_wr = 0; dbg_div_ld = 0;
        pulse_start(); tick(2);
        // R10: reset in the middle of an operation
        rst = 1; tick(2); rst = 0; tick(1);
        // R7: start during the stall ignored even with divider set
        div_wr = 1; div_wdata = 45; cmd_start = 1; tick(1);
        div_wr = 0; cmd_start = 0; tick(6);
        // R5 R6: upper boundary 52 accepted, 53 rejected
        cpu_div(52); pulse_start(); tick(2);
        cmd_done = 1; tick(1); cmd_done = 0;
        cpu_div(53); pulse_start(); tick(3);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule